// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Interrupt

This block is the counting part of a per-core performance monitor. It holds a row of general counters and a row of fixed counters, all of one width. A general counter has its own selector. The selector picks one of many event inputs by code, and it gates counting by privilege mode. A fixed counter is wired to one dedicated event input, and a 4-bit field in a shared control word sets how it counts. A counter advances only when its local control and its bit in a shared global enable word are both set.

Software reaches every register through a synchronous read/write port with a one-cycle read latency. Software loads a counter with the two's complement of N to make it wrap after N events. A wrap rolls the counter to zero and sets a sticky status bit in the same edge. A write-one-to-clear register clears the status bits. When a wrapping counter has its interrupt enabled, a level interrupt rises. Further wraps cannot change the line until software re-arms it.

Top module: `perfmon_bank`

## Requirements
- R1: After reset all counters, selectors, the fixed control word, the global enable word and the overflow status word read zero, and irq_o is low.
- R2: General counter i adds one per cycle in which its selector enable (bit 11) is set, global enable bit i is set, the privilege qualifier passes and the event input picked by selector bits 7:0 is high. The privilege qualifier is selector bit 9 when mode_user is 0 (kernel) and selector bit 8 when mode_user is 1 (user).
- R3: Fixed counter i counts fx_ev[i] when global enable bit 32+i is set and its field at bits 4*i+3:4*i passes the privilege qualifier. The qualifier is field bit 0 in kernel mode and field bit 1 in user mode. Field bit 2 has no effect on counting.
- R4: A selector of all zeros, a cleared selector enable bit or a cleared global enable bit holds the counter at its value.
- R5: A write to a counter is truncated to the counter width. When a write and an increment fall in the same cycle, the written value is kept.
- R6: A counter loaded with 2^48-N wraps on exactly the Nth counted event. At the edge of that event it rolls to zero and sets status bit i (general) or 32+i (fixed).
- R7: Writing the clear register (address 3) clears each status bit written as 1 and leaves the other bits alone. A wrap in the same cycle as its clear leaves the bit set. Writes to the status register (address 2) are ignored.
- R8: irq_o rises at the edge of a wrap only on a counter whose interrupt enable is set. For a general counter this is selector bit 10. For a fixed counter it is field bit 3.
- R9: Once high, irq_o stays high through status clears and later wraps. A write with bit 0 set to address 5 lowers it, and only a new interrupt-enabled wrap raises it again.
- R10: The capability word (address 0) reads version 2 in bits 7:0, the general counter count in 15:8, the general width in 23:16, the fixed counter count in 28:24 and the fixed width in 36:29.
- R11: A read at address A presents its data on reg_rdata one cycle later. The address map is: 1 global enable, 2 status, 4 fixed control, 8+i selector i, 16+i general counter i, 24+i fixed counter i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_user | input | 1 | Current privilege: 1 user, 0 kernel |
| gp_ev | input | EV_N | Event inputs picked by general selectors |
| fx_ev | input | NUM_FX | Dedicated event input per fixed counter |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after reg_rd |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The hardest case to reach is a wrap that lands in the same cycle as a write touching the same state: a clear of its own status bit, or a counter load while its event is high. The bench preloads counters next to the wrap point, then drives the event in the same cycle as the colliding write. Randomized rounds pick the counter, event code, distance to wrap, event count and privilege from a fixed seed. A model predicts each final value and status bit. Directed runs cover the interrupt mask and re-arm sequence.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int REG_AW = 5;
  localparam int SELW   = 12;

  localparam logic [REG_AW-1:0] A_CAP   = 5'd0;
  localparam logic [REG_AW-1:0] A_GEN   = 5'd1;
  localparam logic [REG_AW-1:0] A_STAT  = 5'd2;
  localparam logic [REG_AW-1:0] A_CLR   = 5'd3;
  localparam logic [REG_AW-1:0] A_FXC   = 5'd4;
  localparam logic [REG_AW-1:0] A_REARM = 5'd5;
  localparam int A_SEL_BASE = 8;
  localparam int A_GPC_BASE = 16;
  localparam int A_FXV_BASE = 24;

  localparam int SEL_USR = 8;
  localparam int SEL_OS  = 9;
  localparam int SEL_INT = 10;
  localparam int SEL_EN  = 11;

  localparam int FX_OS  = 0;
  localparam int FX_USR = 1;
  localparam int FX_INT = 3;
  localparam int FX_FLD = 4;
  localparam int FX_BIT = 32;

  function automatic logic [63:0] cap_word(int ver, int ngp, int gw, int nfx, int fw);
    logic [63:0] c;
    c = '0;
    c[7:0]   = 8'(ver);
    c[15:8]  = 8'(ngp);
    c[23:16] = 8'(gw);
    c[28:24] = 5'(nfx);
    c[36:29] = 8'(fw);
    return c;
  endfunction
endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] value,
  output logic          wrap
);
  // a load in the same cycle suppresses the increment and the wrap
  assign wrap = inc && !ld && (&value);

  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (ld)  value <= ld_val;
    else if (inc) value <= value + 1'b1;
  end
endmodule

// File: rtl/perfmon_gp_slot.sv
module perfmon_gp_slot
  import perfmon_pkg::*;
#(
  parameter int CW   = 48,
  parameter int EV_N = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_we,
  input  logic [SELW-1:0] sel_wdata,
  input  logic            cnt_we,
  input  logic [CW-1:0]   cnt_wdata,
  input  logic [EV_N-1:0] ev_in,
  input  logic            mode_user,
  input  logic            glb_en,
  output logic [SELW-1:0] sel_q,
  output logic [CW-1:0]   value,
  output logic            wrap,
  output logic            int_en
);
  localparam int CODE_W = (EV_N > 1) ? $clog2(EV_N) : 1;

  logic [7:0] code;
  logic       code_ok;
  logic       ev_hit;
  logic       priv_ok;
  logic       inc;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_we) sel_q <= sel_wdata;
  end

  assign code    = sel_q[7:0];
  assign code_ok = ({24'd0, code} < EV_N);
  assign ev_hit  = code_ok && ev_in[code[CODE_W-1:0]];
  assign priv_ok = mode_user ? sel_q[SEL_USR] : sel_q[SEL_OS];
  assign inc     = sel_q[SEL_EN] && glb_en && priv_ok && ev_hit;
  assign int_en  = sel_q[SEL_INT];

  perfmon_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc    (inc),
    .ld     (cnt_we),
    .ld_val (cnt_wdata),
    .value  (value),
    .wrap   (wrap)
  );
endmodule

// File: rtl/perfmon_fx_slot.sv
module perfmon_fx_slot #(
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          f_os,
  input  logic          f_usr,
  input  logic          f_int,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          ev,
  input  logic          mode_user,
  input  logic          glb_en,
  output logic [CW-1:0] value,
  output logic          wrap,
  output logic          int_en
);
  logic priv_ok;
  logic inc;

  assign priv_ok = mode_user ? f_usr : f_os;
  assign inc     = glb_en && priv_ok && ev;
  assign int_en  = f_int;

  perfmon_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc    (inc),
    .ld     (cnt_we),
    .ld_val (cnt_wdata),
    .value  (value),
    .wrap   (wrap)
  );
endmodule

// File: rtl/perfmon_irq.sv
module perfmon_irq (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic rearm,
  output logic irq_o
);
  // high line is the masked state; a request in the re-arm cycle is kept
  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (rearm) irq_o <= req;
    else if (req)   irq_o <= 1'b1;
  end
endmodule

// File: rtl/perfmon_bank.sv
module perfmon_bank
  import perfmon_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FX  = 3,
  parameter int CW      = 48,
  parameter int EV_N    = 256,
  parameter int VERSION = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_user,
  input  logic [EV_N-1:0]   gp_ev,
  input  logic [NUM_FX-1:0] fx_ev,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              irq_o
);
  localparam int FXCW = FX_FLD * NUM_FX;
  localparam logic [63:0] GLB_MASK =
    ((64'd1 << NUM_GP) - 64'd1) | (((64'd1 << NUM_FX) - 64'd1) << FX_BIT);
  localparam logic [63:0] CAP = cap_word(VERSION, NUM_GP, CW, NUM_FX, CW);

  logic [63:0]                  glb_q;
  logic [63:0]                  status_q;
  logic [FXCW-1:0]              fxc_q;
  logic [63:0]                  wrap_vec;
  logic [63:0]                  clr_vec;
  logic [NUM_GP-1:0]            gp_sel_we;
  logic [NUM_GP-1:0]            gp_cnt_we;
  logic [NUM_FX-1:0]            fx_cnt_we;
  logic [NUM_GP-1:0][SELW-1:0]  gp_sel;
  logic [NUM_GP-1:0][CW-1:0]    gp_val;
  logic [NUM_FX-1:0][CW-1:0]    fx_val;
  logic [NUM_GP-1:0]            gp_wrap;
  logic [NUM_GP-1:0]            gp_int;
  logic [NUM_FX-1:0]            fx_wrap;
  logic [NUM_FX-1:0]            fx_int;
  logic                         irq_req;
  logic                         rearm;
  logic [63:0]                  rd_mux;

  generate
    for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
      assign gp_sel_we[i] = reg_wr && (reg_addr == 5'(A_SEL_BASE + i));
      assign gp_cnt_we[i] = reg_wr && (reg_addr == 5'(A_GPC_BASE + i));
      perfmon_gp_slot #(.CW(CW), .EV_N(EV_N)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (gp_sel_we[i]),
        .sel_wdata (reg_wdata[SELW-1:0]),
        .cnt_we    (gp_cnt_we[i]),
        .cnt_wdata (reg_wdata[CW-1:0]),
        .ev_in     (gp_ev),
        .mode_user (mode_user),
        .glb_en    (glb_q[i]),
        .sel_q     (gp_sel[i]),
        .value     (gp_val[i]),
        .wrap      (gp_wrap[i]),
        .int_en    (gp_int[i])
      );
    end
    for (genvar i = 0; i < NUM_FX; i++) begin : g_fx
      assign fx_cnt_we[i] = reg_wr && (reg_addr == 5'(A_FXV_BASE + i));
      perfmon_fx_slot #(.CW(CW)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .f_os      (fxc_q[FX_FLD*i + FX_OS]),
        .f_usr     (fxc_q[FX_FLD*i + FX_USR]),
        .f_int     (fxc_q[FX_FLD*i + FX_INT]),
        .cnt_we    (fx_cnt_we[i]),
        .cnt_wdata (reg_wdata[CW-1:0]),
        .ev        (fx_ev[i]),
        .mode_user (mode_user),
        .glb_en    (glb_q[FX_BIT + i]),
        .value     (fx_val[i]),
        .wrap      (fx_wrap[i]),
        .int_en    (fx_int[i])
      );
    end
  endgenerate

  always_comb begin
    wrap_vec = '0;
    wrap_vec[NUM_GP-1:0] = gp_wrap;
    wrap_vec[FX_BIT +: NUM_FX] = fx_wrap;
  end

  assign clr_vec = (reg_wr && reg_addr == A_CLR) ? reg_wdata : 64'd0;
  assign irq_req = |(gp_wrap & gp_int) || |(fx_wrap & fx_int);
  assign rearm   = reg_wr && (reg_addr == A_REARM) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_q    <= '0;
      fxc_q    <= '0;
      status_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_GEN) glb_q <= reg_wdata & GLB_MASK;
      if (reg_wr && reg_addr == A_FXC) fxc_q <= reg_wdata[FXCW-1:0];
      status_q <= (status_q & ~clr_vec) | wrap_vec;
    end
  end

  perfmon_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .req   (irq_req),
    .rearm (rearm),
    .irq_o (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CAP:  rd_mux = CAP;
      A_GEN:  rd_mux = glb_q;
      A_STAT: rd_mux = status_q;
      A_FXC:  rd_mux = 64'(fxc_q);
      default: begin
        for (int i = 0; i < NUM_GP; i++) begin
          if (reg_addr == 5'(A_SEL_BASE + i)) rd_mux = 64'(gp_sel[i]);
          if (reg_addr == 5'(A_GPC_BASE + i)) rd_mux = 64'(gp_val[i]);
        end
        for (int i = 0; i < NUM_FX; i++) begin
          if (reg_addr == 5'(A_FXV_BASE + i)) rd_mux = 64'(fx_val[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/perfmon_bank_chk.sv
module perfmon_bank_chk
  import perfmon_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FX  = 3,
  parameter int CW      = 48,
  parameter int VERSION = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      reg_wr,
  input logic                      reg_rd,
  input logic [4:0]                reg_addr,
  input logic [63:0]               reg_wdata,
  input logic [63:0]               reg_rdata,
  input logic                      irq_o,
  input logic                      irq_req,
  input logic [63:0]               status_q,
  input logic [63:0]               wrap_vec,
  input logic [63:0]               glb_q,
  input logic [NUM_GP-1:0]         gp_cnt_we,
  input logic [NUM_GP-1:0][CW-1:0] gp_val
);
  localparam logic [63:0] CAPX = cap_word(VERSION, NUM_GP, CW, NUM_FX, CW);

  logic        rearm_w;
  logic [63:0] clr_w;
  assign rearm_w = reg_wr && reg_addr == A_REARM && reg_wdata[0];
  assign clr_w   = (reg_wr && reg_addr == A_CLR) ? reg_wdata : 64'd0;

  // R8: the line only rises after an interrupt-enabled wrap
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(irq_req));

  // R9: the line holds until a re-arm write
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o && !rearm_w |=> irq_o);

  // R7: a status bit drops only when written to the clear register
  p_status_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q | $past(clr_w)) & $past(status_q)) == $past(status_q));

  // R6: every wrap lands in the status word
  p_wrap_status_r6: assert property (@(posedge clk) disable iff (rst)
    (|wrap_vec) |=> (status_q & $past(wrap_vec)) == $past(wrap_vec));

  // R10: capability read returns the fixed layout
  p_cap_read_r10: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == A_CAP |=> reg_rdata == CAPX);

  generate
    for (genvar i = 0; i < NUM_GP; i++) begin : g_hold
      // R4: no global enable, no write, no change
      p_no_count_r4: assert property (@(posedge clk) disable iff (rst)
        !glb_q[i] && !gp_cnt_we[i] |=> $stable(gp_val[i]));
    end
  endgenerate
endmodule

bind perfmon_bank perfmon_bank_chk #(
  .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .CW(CW), .VERSION(VERSION)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .irq_req   (irq_req),
  .status_q  (status_q),
  .wrap_vec  (wrap_vec),
  .glb_q     (glb_q),
  .gp_cnt_we (gp_cnt_we),
  .gp_val    (gp_val)
);

// File: tb/perfmon_bank_bench.sv
module perfmon_bank_bench;
  localparam int CW = 48;
  localparam logic [47:0] MAXV = {48{1'b1}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_user = 1'b0;
  logic [255:0] gp_ev = '0;
  logic [2:0]  fx_ev = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  perfmon_bank u_perfmon_bank (
    .clk(clk), .rst(rst), .mode_user(mode_user), .gp_ev(gp_ev), .fx_ev(fx_ev),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] sel_word(bit en, bit ie, bit os, bit usr, int code);
    return (64'(en) << 11) | (64'(ie) << 10) | (64'(os) << 9) | (64'(usr) << 8) | 64'(code[7:0]);
  endfunction

  function automatic logic [47:0] model_cnt(logic [47:0] start, int n);
    return start + 48'(n);
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [63:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_gp(int code, int n);
    gp_ev[code] = 1'b1;
    repeat (n) @(negedge clk);
    gp_ev[code] = 1'b0;
  endtask

  task automatic pulse_fx(int idx, int n);
    fx_ev[idx] = 1'b1;
    repeat (n) @(negedge clk);
    fx_ev[idx] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(5'd1, d);  chk("R1 global", d, 0);
    rd(5'd2, d);  chk("R1 status", d, 0);
    rd(5'd4, d);  chk("R1 fixed ctrl", d, 0);
    rd(5'd16, d); chk("R1 counter0", d, 0);
    rd(5'd8, d);  chk("R1 selector0", d, 0);
    chk("R1 irq", 64'(irq_o), 0);

    // R10 capability, R11 map
    rd(5'd0, d);
    chk("R10 cap", d, 64'd2 | (64'd4 << 8) | (64'd48 << 16) | (64'd3 << 24) | (64'd48 << 29));
    wr(5'd1, 64'h0000_0007_0000_000F);
    rd(5'd1, d); chk("R11 global readback", d, 64'h0000_0007_0000_000F);

    // R4 zero selector does not count
    pulse_gp(0, 4);
    rd(5'd16, d); chk("R4 zero selector", d, 0);

    // R2 basic count with privilege
    wr(5'd8, sel_word(1, 0, 1, 0, 3));
    pulse_gp(3, 5);
    rd(5'd16, d); chk("R2 kernel count", d, 5);
    mode_user = 1'b1;
    pulse_gp(3, 4);
    rd(5'd16, d); chk("R2 user blocked", d, 5);
    pulse_gp(4, 3);
    mode_user = 1'b0;
    pulse_gp(4, 3);
    rd(5'd16, d); chk("R2 other code ignored", d, 5);

    // R4 global bit off holds the counter
    wr(5'd1, 64'h0000_0007_0000_000E);
    pulse_gp(3, 6);
    rd(5'd16, d); chk("R4 global off", d, 5);
    wr(5'd1, 64'h0000_0007_0000_000F);

    // R5 truncation and write priority
    wr(5'd17, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(5'd17, d); chk("R5 truncate", d, 64'(MAXV));
    wr(5'd9, sel_word(1, 0, 1, 0, 5));
    gp_ev[5] = 1'b1;
    wr(5'd17, 64'd100);
    rd(5'd17, d); chk("R5 write beats increment", d, 100);
    gp_ev[5] = 1'b0;
    rd(5'd17, d); chk("R5 increment after write", d, 101);

    // R6 exact wrap distance
    wr(5'd16, 64'(MAXV - 48'd2));
    pulse_gp(3, 2);
    rd(5'd16, d); chk("R6 before wrap", d, 64'(MAXV));
    rd(5'd2, d);  chk("R6 no status yet", d, 0);
    pulse_gp(3, 1);
    rd(5'd16, d); chk("R6 rolled to zero", d, 0);
    rd(5'd2, d);  chk("R6 status bit0", d, 1);
    wr(5'd3, 64'd1);

    // R3 fixed counters
    wr(5'd4, 64'h001);
    pulse_fx(0, 5);
    rd(5'd24, d); chk("R3 fixed kernel", d, 5);
    mode_user = 1'b1;
    pulse_fx(0, 4);
    rd(5'd24, d); chk("R3 fixed user blocked", d, 5);
    wr(5'd4, 64'h002);
    pulse_fx(0, 3);
    rd(5'd24, d); chk("R3 fixed user", d, 8);
    mode_user = 1'b0;
    wr(5'd4, 64'h004);
    pulse_fx(0, 3);
    rd(5'd24, d); chk("R3 any-thread bit alone", d, 8);
    wr(5'd4, 64'h007);
    pulse_fx(0, 2);
    rd(5'd24, d); chk("R3 any-thread bit no effect", d, 10);
    wr(5'd1, 64'h0000_0006_0000_000F);
    pulse_fx(0, 3);
    rd(5'd24, d); chk("R3 fixed global off", d, 10);
    wr(5'd1, 64'h0000_0007_0000_000F);

    // R7 split layout, selective clear, ignored status write
    wr(5'd4, 64'h017);
    wr(5'd25, 64'(MAXV));
    pulse_fx(1, 1);
    wr(5'd16, 64'(MAXV));
    pulse_gp(3, 1);
    rd(5'd2, d); chk("R7 two status bits", d, 64'h0000_0002_0000_0001);
    wr(5'd3, 64'd1);
    rd(5'd2, d); chk("R7 clear one bit", d, 64'h0000_0002_0000_0000);
    wr(5'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(5'd2, 64'd0);
    rd(5'd2, d); chk("R7 status write ignored", d, 64'h0000_0002_0000_0000);
    wr(5'd3, 64'h0000_0002_0000_0000);

    // R7 wrap and clear in the same cycle
    wr(5'd10, sel_word(1, 0, 1, 0, 7));
    wr(5'd18, 64'(MAXV));
    gp_ev[7] = 1'b1;
    wr(5'd3, 64'd4);
    gp_ev[7] = 1'b0;
    rd(5'd2, d); chk("R7 set wins over clear", d, 4);
    wr(5'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 no irq without enable", 64'(irq_o), 0);

    // R6 random rounds against the model
    for (int it = 0; it < 24; it++) begin
      int idx;
      int code;
      int r;
      int n;
      bit os;
      bit usr;
      bit pu;
      bit q;
      int expn;
      logic [47:0] start;
      idx  = $urandom_range(0, 3);
      code = $urandom_range(0, 255);
      r    = $urandom_range(1, 12);
      n    = $urandom_range(0, 12);
      os   = 1'($urandom_range(0, 1));
      usr  = 1'($urandom_range(0, 1));
      pu   = 1'($urandom_range(0, 1));
      start = 48'(0) - 48'(r);
      wr(5'(8 + idx), sel_word(1, 0, os, usr, code));
      wr(5'(16 + idx), 64'(start));
      mode_user = pu;
      pulse_gp(code, n);
      mode_user = 1'b0;
      q = pu ? usr : os;
      expn = q ? n : 0;
      rd(5'(16 + idx), d); chk("R6 random value", d, 64'(model_cnt(start, expn)));
      rd(5'd2, d); chk("R6 random status", d, (expn >= r) ? (64'd1 << idx) : 64'd0);
      wr(5'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(5'(8 + idx), 64'd0);
    end
    chk("R8 random rounds no irq", 64'(irq_o), 0);

    // R8 / R9 interrupt and masking
    wr(5'd11, sel_word(1, 1, 1, 0, 9));
    wr(5'd19, 64'(MAXV - 48'd1));
    pulse_gp(9, 1);
    chk("R8 no irq before wrap", 64'(irq_o), 0);
    pulse_gp(9, 1);
    chk("R8 irq on wrap", 64'(irq_o), 1);
    wr(5'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R9 irq holds through clear", 64'(irq_o), 1);
    wr(5'd5, 64'd0);
    chk("R9 rearm needs bit0", 64'(irq_o), 1);
    wr(5'd5, 64'd1);
    chk("R9 rearm lowers irq", 64'(irq_o), 0);
    pulse_gp(9, 3);
    chk("R9 no irq without new wrap", 64'(irq_o), 0);
    wr(5'd4, 64'h900);
    wr(5'd26, 64'(MAXV));
    pulse_fx(2, 1);
    chk("R8 fixed irq on wrap", 64'(irq_o), 1);
    rd(5'd2, d); chk("R6 fixed2 status", d, 64'h0000_0004_0000_0000);
    wr(5'd5, 64'd1);
    chk("R9 rearm again", 64'(irq_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule